// File: doc/BRIEF.md
# Byte-serial instruction length decoder

This block walks a stream of 16-bit machine-code bytes, one byte per accepted transfer, and marks where every instruction stops. Each byte is labelled with the role it plays: prefix, opcode, postbyte (mode/register/memory byte), displacement or immediate. The byte that closes an instruction also carries an end flag and the total byte count of that instruction, prefixes included. The parse then starts over with the next byte. An upstream fetch unit feeds the input, and a decode or alignment stage uses the labels and the end marks to cut the stream into whole instructions.

Labels and end marks are worked out combinationally from the current byte and the parser state, so each byte's result appears in the same transfer that carries it. The output stream has no storage of its own. Back-pressure passes straight through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. A byte is consumed only in a cycle where both `in_valid` and `out_ready` are high. In every other cycle the parser state is frozen, and the producer must keep the same byte on `in_byte`.

Top module: `insn_len_decoder`

## Requirements
- R1: The bytes 26, 2E, 36, 3E, F0, F2 and F3 (hex), when they arrive at an instruction start, get tag 0 (prefix). They never end the instruction, and each one adds 1 to its length.
- R2: An opcode byte gets tag 1. An opcode with no trailing bytes (for example 90, F4, 40) ends the instruction on that same byte.
- R3: A postbyte (tag 2) sets the displacement length that follows it (tag 3) from mod = bits 7:6 and r/m = bits 2:0: mod 00 with r/m 110 gives 2 bytes; any other mod 00 gives 0; mod 01 gives 1; mod 10 gives 2; mod 11 gives 0.
- R4: Opcodes 80, 82 and 83 take a postbyte and then 1 immediate byte (tag 4). Opcode 81 takes a postbyte and then 2 immediate bytes. In every case the displacement bytes come before the immediate bytes.
- R5: Opcodes F6 and F7 take an immediate of 1 or 2 bytes respectively, but only when postbyte bits 5:3 are 000. Any other value of those bits gives no immediate.
- R6: Opcode C8 is followed by 3 immediate bytes (a 2-byte size and then a 1-byte level). Opcodes 9A and EA are followed by 4 immediate bytes (offset and then segment).
- R7: Opcodes 69 and 6B take a postbyte and its displacement, then 2 or 1 immediate bytes respectively. Opcodes C0 and C1 take a postbyte and its displacement, then 1 immediate byte.
- R8: Opcodes D4 and D5 take 1 immediate byte. Opcodes 70 to 7F, E0 to E3 and EB take 1 displacement byte and no postbyte.
- R9: `out_last` is high exactly on the final byte of each instruction. On that byte `out_len` is the total byte count, prefixes included. The byte after it is parsed as a prefix or an opcode.
- R10: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. The parser advances only when both `in_valid` and `out_ready` are high. Otherwise `out_len` and the parse position stay unchanged.
- R11: A synchronous `rst` puts the parser back at an instruction start with a count of zero, even in the middle of an instruction.
- R12: The reported length saturates at 2^LEN_W-1 (15 by default) when an instruction is longer than that.
- R13: The other opcodes follow the same scheme. Accumulator-immediate ALU forms (x4/x5 in 00-3F), A8/A9 and register loads B0-BF take 1 or 2 immediate bytes by width. 68, C2 and CA take 2 immediate bytes. 6A, CD and E4-E7 take 1. A0-A3, E8 and E9 take 2 displacement bytes. C6 and C7 take a postbyte and then 1 or 2 immediate bytes. All other postbyte opcodes (ALU forms x0-x3 and x8-xB in 00-3F, 62, 84-8F, C4, C5, D0-D3, D8-DF, FE, FF) take a postbyte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Tag, end flag and length are valid |
| out_ready | input | 1 | Downstream can accept the current result |
| out_tag | output | 3 | Byte role: 0 prefix, 1 opcode, 2 postbyte, 3 displacement, 4 immediate |
| out_last | output | 1 | Current byte ends the instruction |
| out_len | output | LEN_W | Byte count of the instruction so far, including the current byte |

## Verification
The hardest case to reach is a postbyte whose own fields decide the rest of the instruction. This happens with the F6/F7 group, where bits 5:3 switch the immediate on or off, combined with a mod value that inserts displacement bytes before that immediate. The stimulus therefore sends F6/F7 with several extension values and with all four mod values. It also stalls and inserts bubbles in the middle of such sequences, so the pending displacement and immediate counts must survive cycles in which nothing is consumed. A run of sixteen prefixes drives the length counter into saturation.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [2:0] {
    TAG_PFX  = 3'd0,
    TAG_OPC  = 3'd1,
    TAG_PB   = 3'd2,
    TAG_DISP = 3'd3,
    TAG_IMM  = 3'd4
  } tag_e;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_PB,
    ST_DISP,
    ST_IMM
  } stage_e;

  // Shape of an instruction as known from its opcode byte alone
  typedef struct packed {
    logic       is_prefix;
    logic       has_modrm;
    logic       test_grp;   // immediate present only for extension 000
    logic [1:0] disp_n;     // displacement bytes without postbyte
    logic [2:0] imm_n;      // immediate bytes without postbyte
    logic [1:0] mimm_n;     // immediate bytes after postbyte/displacement
  } op_info_t;

endpackage

// File: rtl/ild_op_class.sv
module ild_op_class
  import ild_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);

  always_comb begin
    info = '0;
    casez (op)
      8'h26, 8'h2E, 8'h36, 8'h3E,
      8'hF0, 8'hF2, 8'hF3:          info.is_prefix = 1'b1;
      8'b00???0??:                  info.has_modrm = 1'b1;
      8'b00???100:                  info.imm_n     = 3'd1;
      8'b00???101:                  info.imm_n     = 3'd2;
      8'h62:                        info.has_modrm = 1'b1;
      8'h68:                        info.imm_n     = 3'd2;
      8'h69: begin info.has_modrm = 1'b1; info.mimm_n = 2'd2; end
      8'h6A:                        info.imm_n     = 3'd1;
      8'h6B: begin info.has_modrm = 1'b1; info.mimm_n = 2'd1; end
      8'b0111????:                  info.disp_n    = 2'd1;
      8'h81: begin info.has_modrm = 1'b1; info.mimm_n = 2'd2; end
      8'b100000??: begin info.has_modrm = 1'b1; info.mimm_n = 2'd1; end
      8'b1000????:                  info.has_modrm = 1'b1;
      8'h9A, 8'hEA:                 info.imm_n     = 3'd4;
      8'b101000??:                  info.disp_n    = 2'd2;
      8'hA8:                        info.imm_n     = 3'd1;
      8'hA9:                        info.imm_n     = 3'd2;
      8'b10110???:                  info.imm_n     = 3'd1;
      8'b10111???:                  info.imm_n     = 3'd2;
      8'hC0, 8'hC1, 8'hC6: begin info.has_modrm = 1'b1; info.mimm_n = 2'd1; end
      8'hC7: begin info.has_modrm = 1'b1; info.mimm_n = 2'd2; end
      8'hC2, 8'hCA:                 info.imm_n     = 3'd2;
      8'hC4, 8'hC5:                 info.has_modrm = 1'b1;
      8'hC8:                        info.imm_n     = 3'd3;
      8'hCD, 8'hD4, 8'hD5:          info.imm_n     = 3'd1;
      8'b110100??:                  info.has_modrm = 1'b1;
      8'b11011???:                  info.has_modrm = 1'b1;
      8'b111000??, 8'hEB:           info.disp_n    = 2'd1;
      8'b111001??:                  info.imm_n     = 3'd1;
      8'hE8, 8'hE9:                 info.disp_n    = 2'd2;
      8'hF6: begin info.has_modrm = 1'b1; info.test_grp = 1'b1; info.mimm_n = 2'd1; end
      8'hF7: begin info.has_modrm = 1'b1; info.test_grp = 1'b1; info.mimm_n = 2'd2; end
      8'hFE, 8'hFF:                 info.has_modrm = 1'b1;
      default:                      info = '0;
    endcase
  end

endmodule

// File: rtl/ild_modrm_disp.sv
module ild_modrm_disp (
  input  logic [7:0] pb,
  output logic [1:0] disp_n
);

  logic [1:0] md;
  logic [2:0] rm;

  assign md = pb[7:6];
  assign rm = pb[2:0];

  always_comb begin
    unique case (md)
      2'b00:   disp_n = (rm == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   disp_n = 2'd1;
      2'b10:   disp_n = 2'd2;
      default: disp_n = 2'd0;
    endcase
  end

endmodule

// File: rtl/ild_len_ctr.sv
module ild_len_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             done,
  output logic [LEN_W-1:0] cur_len
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] seen_q;

  assign cur_len = (seen_q == LEN_MAX) ? LEN_MAX : seen_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
    end else if (adv) begin
      seen_q <= done ? '0 : cur_len;
    end
  end

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_tag,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len
);

  op_info_t   info;
  logic [1:0] pb_disp;
  logic       fire;

  stage_e     stage_q, stage_d;
  logic [1:0] disp_q, disp_d;
  logic [2:0] imm_q, imm_d;
  logic [1:0] mimm_q, mimm_d;
  logic       tst_q, tst_d;
  tag_e       tag;
  logic       last;
  logic [2:0] pb_imm;

  ild_op_class u_cls (
    .op   (in_byte),
    .info (info)
  );

  ild_modrm_disp u_md (
    .pb     (in_byte),
    .disp_n (pb_disp)
  );

  ild_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst     (rst),
    .adv     (fire),
    .done    (last),
    .cur_len (out_len)
  );

  assign fire      = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_tag   = tag;
  assign out_last  = last;

  // Immediate size once the postbyte is known
  assign pb_imm = (tst_q && (in_byte[5:3] != 3'b000)) ? 3'd0 : {1'b0, mimm_q};

  always_comb begin
    stage_d = stage_q;
    disp_d  = disp_q;
    imm_d   = imm_q;
    mimm_d  = mimm_q;
    tst_d   = tst_q;
    tag     = TAG_OPC;
    last    = 1'b0;
    unique case (stage_q)
      ST_HEAD: begin
        if (info.is_prefix) begin
          tag = TAG_PFX;
        end else begin
          tag = TAG_OPC;
          if (info.has_modrm) begin
            stage_d = ST_PB;
            mimm_d  = info.mimm_n;
            tst_d   = info.test_grp;
          end else if (info.disp_n != 2'd0) begin
            stage_d = ST_DISP;
            disp_d  = info.disp_n;
            imm_d   = 3'd0;
          end else if (info.imm_n != 3'd0) begin
            stage_d = ST_IMM;
            imm_d   = info.imm_n;
          end else begin
            last = 1'b1;
          end
        end
      end
      ST_PB: begin
        tag = TAG_PB;
        if (pb_disp != 2'd0) begin
          stage_d = ST_DISP;
          disp_d  = pb_disp;
          imm_d   = pb_imm;
        end else if (pb_imm != 3'd0) begin
          stage_d = ST_IMM;
          imm_d   = pb_imm;
        end else begin
          stage_d = ST_HEAD;
          last    = 1'b1;
        end
      end
      ST_DISP: begin
        tag = TAG_DISP;
        if (disp_q > 2'd1) begin
          disp_d = disp_q - 2'd1;
        end else if (imm_q != 3'd0) begin
          stage_d = ST_IMM;
        end else begin
          stage_d = ST_HEAD;
          last    = 1'b1;
        end
      end
      default: begin
        tag = TAG_IMM;
        if (imm_q > 3'd1) begin
          imm_d = imm_q - 3'd1;
        end else begin
          stage_d = ST_HEAD;
          last    = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_HEAD;
      disp_q  <= '0;
      imm_q   <= '0;
      mimm_q  <= '0;
      tst_q   <= 1'b0;
    end else if (fire) begin
      stage_q <= stage_d;
      disp_q  <= disp_d;
      imm_q   <= imm_d;
      mimm_q  <= mimm_d;
      tst_q   <= tst_d;
    end
  end

endmodule

// File: rtl/ild_checker.sv
module ild_checker
  import ild_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [2:0]       out_tag,
  input logic             out_last,
  input logic [LEN_W-1:0] out_len
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic fire;
  assign fire = in_valid && in_ready;

  a_r1_prefix_not_last: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == TAG_PFX) |-> !out_last);

  a_r10_idle_keeps_len: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(out_len));

  a_r12_len_step: assert property (@(posedge clk) disable iff (rst)
    (fire && !out_last) |=>
      out_len == (($past(out_len) == LEN_MAX) ? LEN_MAX : $past(out_len) + 1'b1));

  a_r9_restart_len: assert property (@(posedge clk) disable iff (rst)
    (fire && out_last) |=> out_len == 1);

  a_r9_restart_tag: assert property (@(posedge clk) disable iff (rst)
    (fire && out_last) |=> (out_valid |-> (out_tag == TAG_PFX || out_tag == TAG_OPC)));

  a_r3_disp_tail: assert property (@(posedge clk) disable iff (rst)
    (fire && out_tag == TAG_DISP && !out_last) |=>
      (out_valid |-> (out_tag == TAG_DISP || out_tag == TAG_IMM)));

  a_r11_reset_len: assert property (@(posedge clk)
    $past(rst) |-> out_len == 1);

endmodule

bind insn_len_decoder ild_checker #(.LEN_W(LEN_W)) u_ild_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_last  (out_last),
  .out_len   (out_len)
);

// File: tb/insn_len_decoder_tb_top.sv
module insn_len_decoder_tb_top;

  localparam int CLK_P = 10;
  localparam int LW    = 4;
  localparam int MAXL  = (1 << LW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_byte = 8'h00;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [2:0]    out_tag;
  logic          out_last;
  logic [LW-1:0] out_len;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_cnt = 0;
  int m_tail[$];
  bit m_want_pb = 0;
  int m_mimm = 0;
  bit m_tst = 0;

  always #(CLK_P/2) clk = ~clk;

  insn_len_decoder #(.LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_last(out_last), .out_len(out_len)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // opcode shape: postbyte?, displacement bytes, immediate bytes, imm after postbyte, test group
  task automatic shape(input int op, output bit pb, output int nd, output int ni,
                       output int mi, output bit tg);
    pb = 0; nd = 0; ni = 0; mi = 0; tg = 0;
    if (op < 'h40) begin
      if (op % 8 < 4) pb = 1;
      else if (op % 8 == 4) ni = 1;
      else if (op % 8 == 5) ni = 2;
    end else if (op >= 'h70 && op <= 'h7F) nd = 1;
    else if (op >= 'h84 && op <= 'h8F) pb = 1;
    else if (op >= 'hA0 && op <= 'hA3) nd = 2;
    else if (op >= 'hB0 && op <= 'hB7) ni = 1;
    else if (op >= 'hB8 && op <= 'hBF) ni = 2;
    else if ((op >= 'hD0 && op <= 'hD3) || (op >= 'hD8 && op <= 'hDF)) pb = 1;
    else if (op >= 'hE0 && op <= 'hE3) nd = 1;
    else if (op >= 'hE4 && op <= 'hE7) ni = 1;
    else begin
      case (op)
        'h62, 'hC4, 'hC5, 'hFE, 'hFF: pb = 1;
        'h68, 'hC2, 'hCA: ni = 2;
        'h6A, 'hCD, 'hD4, 'hD5, 'hA8: ni = 1;
        'hA9: ni = 2;
        'h69, 'h81, 'hC7: begin pb = 1; mi = 2; end
        'h6B, 'h80, 'h82, 'h83, 'hC0, 'hC1, 'hC6: begin pb = 1; mi = 1; end
        'hF6: begin pb = 1; mi = 1; tg = 1; end
        'hF7: begin pb = 1; mi = 2; tg = 1; end
        'h9A, 'hEA: ni = 4;
        'hC8: ni = 3;
        'hE8, 'hE9: nd = 2;
        'hEB: nd = 1;
        default: ;
      endcase
    end
  endtask

  function automatic bit is_pfx(input int b);
    return b == 'h26 || b == 'h2E || b == 'h36 || b == 'h3E ||
           b == 'hF0 || b == 'hF2 || b == 'hF3;
  endfunction

  task automatic step(input string r, input int b, input bit v, input bit rdy);
    int exp_tag;
    bit exp_last;
    int exp_len;
    @(negedge clk);
    in_byte = b[7:0]; in_valid = v; out_ready = rdy;
    #(CLK_P/4);
    exp_len = (m_cnt + 1 > MAXL) ? MAXL : m_cnt + 1;
    chk("R10", "out_valid", out_valid, v);
    chk("R10", "in_ready", in_ready, rdy);
    chk(r, "out_len (R9/R12)", out_len, exp_len);
    if (v && rdy) begin
      if (m_want_pb) begin
        int nd;
        exp_tag = 2;
        m_want_pb = 0;
        nd = (b[7:6] == 2'b01) ? 1 : (b[7:6] == 2'b10) ? 2 :
             (b[7:6] == 2'b00 && b[2:0] == 3'b110) ? 2 : 0;
        for (int i = 0; i < nd; i++) m_tail.push_back(3);
        if (!(m_tst && b[5:3] != 3'b000))
          for (int i = 0; i < m_mimm; i++) m_tail.push_back(4);
        exp_last = (m_tail.size() == 0);
      end else if (m_tail.size() != 0) begin
        exp_tag = m_tail.pop_front();
        exp_last = (m_tail.size() == 0);
      end else if (is_pfx(b)) begin
        exp_tag = 0;
        exp_last = 0;
      end else begin
        bit pb, tg;
        int nd, ni, mi;
        shape(b, pb, nd, ni, mi, tg);
        exp_tag = 1;
        m_want_pb = pb; m_mimm = mi; m_tst = tg;
        for (int i = 0; i < nd; i++) m_tail.push_back(3);
        for (int i = 0; i < ni; i++) m_tail.push_back(4);
        exp_last = !pb && (m_tail.size() == 0);
      end
      chk(r, "out_tag", out_tag, exp_tag);
      chk(r, "out_last (R9)", out_last, exp_last);
      m_cnt = exp_last ? 0 : exp_len;
    end
  endtask

  task automatic put(input string r, input int b);
    step(r, b, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_tail.delete(); m_want_pb = 0; m_mimm = 0; m_tst = 0;
  endtask

  initial begin
    do_reset();
    // R11: reset state
    #(CLK_P/4);
    chk("R11", "len after reset", out_len, 1);
    put("R11", 'h90);
    // R2: single-byte opcodes
    put("R2", 'h90); put("R2", 'hF4); put("R2", 'h40);
    // R1: prefixes
    put("R1", 'h26); put("R1", 'hF3); put("R1", 'hA4);
    put("R1", 'hF0); put("R1", 'hFE); put("R1", 'hC0);
    put("R1", 'h3E); put("R1", 'h2E); put("R1", 'h36); put("R1", 'hF2); put("R1", 'h90);
    // R3: displacement from postbyte
    put("R3", 'h8B); put("R3", 'h06); put("R3", 'h34); put("R3", 'h12);
    put("R3", 'h8B); put("R3", 'h46); put("R3", 'h08);
    put("R3", 'h8B); put("R3", 'h86); put("R3", 'h00); put("R3", 'h01);
    put("R3", 'h8B); put("R3", 'hC0);
    put("R3", 'h8B); put("R3", 'h07);
    // R4: immediate group
    put("R4", 'h80); put("R4", 'hC0); put("R4", 'h05);
    put("R4", 'h81); put("R4", 'hC0); put("R4", 'h34); put("R4", 'h12);
    put("R4", 'h83); put("R4", 'h46); put("R4", 'h02); put("R4", 'h7F);
    put("R4", 'h82); put("R4", 'hC0); put("R4", 'h01);
    // R5: test group
    put("R5", 'hF6); put("R5", 'hC0); put("R5", 'h55);
    put("R5", 'hF7); put("R5", 'h06); put("R5", 'h00); put("R5", 'h10);
    put("R5", 'hFF); put("R5", 'hFF);
    put("R5", 'hF6); put("R5", 'hD0);
    put("R5", 'hF7); put("R5", 'hE0);
    put("R5", 'hF7); put("R5", 'h40); put("R5", 'h04); put("R5", 'hAA); put("R5", 'hBB);
    put("R5", 'hF7); put("R5", 'h98); put("R5", 'h00); put("R5", 'h02);
    // R6: frame entry and far transfers
    put("R6", 'hC8); put("R6", 'h10); put("R6", 'h00); put("R6", 'h02);
    put("R6", 'h9A); put("R6", 'h00); put("R6", 'h01); put("R6", 'h00); put("R6", 'h20);
    put("R6", 'hEA); put("R6", 'h11); put("R6", 'h22); put("R6", 'h33); put("R6", 'h44);
    // R7: postbyte plus constant
    put("R7", 'h69); put("R7", 'hC3); put("R7", 'h10); put("R7", 'h00);
    put("R7", 'h6B); put("R7", 'h46); put("R7", 'h02); put("R7", 'h05);
    put("R7", 'hC0); put("R7", 'hE0); put("R7", 'h03);
    put("R7", 'hC1); put("R7", 'h86); put("R7", 'h00); put("R7", 'h01); put("R7", 'h04);
    // R8: one-byte constants and short branches
    put("R8", 'hD4); put("R8", 'h0A);
    put("R8", 'hD5); put("R8", 'h0A);
    put("R8", 'h74); put("R8", 'hFE);
    put("R8", 'hE2); put("R8", 'hF0);
    put("R8", 'hEB); put("R8", 'h00);
    // R13: remaining families
    put("R13", 'h05); put("R13", 'h34); put("R13", 'h12);
    put("R13", 'hB0); put("R13", 'h12);
    put("R13", 'hB8); put("R13", 'h34); put("R13", 'h12);
    put("R13", 'hA1); put("R13", 'h00); put("R13", 'h10);
    put("R13", 'hE8); put("R13", 'h00); put("R13", 'h00);
    put("R13", 'hCD); put("R13", 'h21);
    put("R13", 'hC2); put("R13", 'h04); put("R13", 'h00);
    put("R13", 'h68); put("R13", 'h00); put("R13", 'h01);
    put("R13", 'h6A); put("R13", 'h01);
    put("R13", 'hE4); put("R13", 'h60);
    put("R13", 'hC7); put("R13", 'h06); put("R13", 'h00); put("R13", 'h10);
    put("R13", 'h34); put("R13", 'h12);
    // R9: back-to-back boundaries
    put("R9", 'hC3); put("R9", 'h90); put("R9", 'hB0); put("R9", 'h01); put("R9", 'h90);
    // R10: bubbles and stalls mid-instruction
    put("R10", 'hF7); step("R10", 'h40, 1'b0, 1'b1); step("R10", 'h40, 1'b1, 1'b0);
    put("R10", 'h40); step("R10", 'h04, 1'b0, 1'b0); put("R10", 'h04);
    step("R10", 'hAA, 1'b1, 1'b0); step("R10", 'hAA, 1'b1, 1'b0);
    put("R10", 'hAA); put("R10", 'hBB);
    // R12: length saturation
    for (int i = 0; i < 16; i++) put("R12", 'h2E);
    put("R12", 'h90);
    // R11: reset mid-instruction
    put("R11", 'h8B); put("R11", 'h06);
    do_reset();
    put("R11", 'h90);
    put("R11", 'h90);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule